// File: doc/BRIEF.md
# Alternating-Polarity Slave Dial Stepper

This block turns a one-per-second tick into the two leg enables of a full-bridge power stage that advances slave dial clocks. For every second it produces one short drive pulse. The polarity of that pulse alternates from one second to the next, so each dial movement sees a current that is reversed from the one before. A toggle register selects the bridge leg. A width timer counts enables from a 100 Hz cadence and sets how long the pulse lasts.

The block has no data stream, so every pin is a plain control signal. Two independent instances are placed, one fed by the solar-time second and one fed by the sidereal-time second. The bridge transistors, the current limiting and the dials sit outside the block.

Top module: `dial_step_driver`

## Requirements
- R1: While `rst_n` is low, both leg enables are low and the toggle is cleared, so the next pulse uses leg A.
- R2: A `sec_tick` high at a rising clock edge makes exactly one leg enable high from the cycle after that edge.
- R3: The first pulse after reset drives leg A (`leg_a_en`). Each later tick drives the leg opposite to the one the previous tick chose.
- R4: A pulse stays high through PULSE_TICKS (default 10) `cadence_en` edges counted after its tick. It goes low in the cycle after the edge that carries the last of those enables.
- R5: `leg_a_en` and `leg_b_en` are never high in the same cycle.
- R6: Outside a pulse window both enables are low, and `cadence_en` on its own changes neither of them.
- R7: A tick that arrives while a pulse is active switches the drive to the other leg and restarts the width count from zero.
- R8: A `cadence_en` that falls on the same edge as a `sec_tick` is not counted toward the width.
- R9: The pulse length depends only on the number of cadence enables, not on how many clock cycles separate them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sec_tick | input | 1 | One-cycle strobe, once per time-scale second |
| cadence_en | input | 1 | One-cycle strobe at 100 Hz that times the pulse width |
| leg_a_en | output | 1 | Enable for bridge leg A (first polarity) |
| leg_b_en | output | 1 | Enable for bridge leg B (reversed polarity) |

## Verification
The block is first exercised with a cadence enable on every cycle. Then the gap between cadence enables is swept from one to four cycles, which shows whether the width follows the count of enables or the count of clock cycles. A second tick is placed after each possible number of counted enables, zero through nine, so every restart point and its polarity swap is covered. Further runs put a tick and a cadence enable on the same edge, apply a long idle cadence with no tick, and assert reset in the middle of a pulse to show that the leg choice returns to A.

// File: rtl/dial_step_pkg.sv
package dial_step_pkg;
  typedef enum logic [1:0] {
    DRIVE_OFF = 2'b00,
    DRIVE_A   = 2'b01,
    DRIVE_B   = 2'b10
  } drive_e;
endpackage

// File: rtl/polarity_toggle.sv
module polarity_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic use_a
);
  // Cleared by reset; the first step sets it, selecting leg A.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    use_a <= 1'b0;
    else if (step) use_a <= ~use_a;
  end
endmodule

// File: rtl/width_timer.sv
module width_timer #(
  parameter int PULSE_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cadence_en,
  output logic active
);
  localparam int CW = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PULSE_TICKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      // a start always wins over a coincident cadence enable
      active <= 1'b1;
      cnt_q  <= '0;
    end else if (active && cadence_en) begin
      if (cnt_q == LAST) begin
        active <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/leg_steer.sv
module leg_steer
  import dial_step_pkg::*;
(
  input  logic   active,
  input  logic   use_a,
  output drive_e drive
);
  always_comb begin
    if (!active)    drive = DRIVE_OFF;
    else if (use_a) drive = DRIVE_A;
    else            drive = DRIVE_B;
  end
endmodule

// File: rtl/dial_step_driver.sv
module dial_step_driver
  import dial_step_pkg::*;
#(
  parameter int PULSE_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick,
  input  logic cadence_en,
  output logic leg_a_en,
  output logic leg_b_en
);
  logic   use_a;
  logic   active;
  drive_e drive;

  polarity_toggle u_tgl (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (sec_tick),
    .use_a (use_a)
  );

  width_timer #(.PULSE_TICKS(PULSE_TICKS)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (sec_tick),
    .cadence_en (cadence_en),
    .active     (active)
  );

  leg_steer u_steer (
    .active (active),
    .use_a  (use_a),
    .drive  (drive)
  );

  assign leg_a_en = (drive == DRIVE_A);
  assign leg_b_en = (drive == DRIVE_B);
endmodule

// File: rtl/dial_step_driver_chk.sv
module dial_step_driver_chk (
  input logic clk,
  input logic rst_n,
  input logic sec_tick,
  input logic cadence_en,
  input logic leg_a_en,
  input logic leg_b_en
);
  logic on;
  assign on = leg_a_en || leg_b_en;

  AST_LEGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(leg_a_en && leg_b_en)); // R5

  AST_TICK_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> on); // R2

  AST_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(on) |-> $past(sec_tick)); // R2

  AST_RETRIGGER_A_TO_B: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && leg_a_en) |=> leg_b_en); // R7

  AST_RETRIGGER_B_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && leg_b_en) |=> leg_a_en); // R7

  AST_HOLD_NO_CADENCE: assert property (@(posedge clk) disable iff (!rst_n)
    (on && !sec_tick && !cadence_en) |=> ($stable(leg_a_en) && $stable(leg_b_en))); // R4

  AST_FALL_NEEDS_CADENCE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(on) |-> $past(cadence_en)); // R4

  AST_IDLE_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!on && !sec_tick) |=> !on); // R6
endmodule

bind dial_step_driver dial_step_driver_chk u_chk (.*);

// File: tb/dial_step_driver_tb_top.sv
module dial_step_driver_tb_top;
  localparam int W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 1'b0;
  logic cadence_en = 1'b0;
  logic leg_a_en, leg_b_en;

  int checks = 0;
  int fails  = 0;

  // reference state derived from the requirements
  logic m_act = 1'b0;
  logic m_tgl = 1'b0;
  int   m_cnt = 0;

  always #10 clk = ~clk;

  dial_step_driver #(.PULSE_TICKS(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .cadence_en(cadence_en),
    .leg_a_en(leg_a_en), .leg_b_en(leg_b_en)
  );

  task automatic compare(input string tag);
    logic ea, eb;
    ea = m_act && m_tgl;
    eb = m_act && !m_tgl;
    checks++;
    if (leg_a_en !== ea || leg_b_en !== eb) begin
      fails++;
      $display("FAIL %s legs a/b actual %b%b expected %b%b", tag, leg_a_en, leg_b_en, ea, eb);
    end
    checks++;
    if (leg_a_en === 1'b1 && leg_b_en === 1'b1) begin
      fails++;
      $display("FAIL R5 both legs high actual 11 expected not 11");
    end
  endtask

  task automatic cyc(input logic t, input logic c, input string tag);
    sec_tick = t;
    cadence_en = c;
    @(posedge clk);
    if (t) begin
      m_act = 1'b1; m_cnt = 0; m_tgl = !m_tgl;
    end else if (m_act && c) begin
      if (m_cnt == W - 1) begin m_act = 1'b0; m_cnt = 0; end
      else m_cnt++;
    end
    @(negedge clk);
    sec_tick = 1'b0;
    cadence_en = 1'b0;
    compare(tag);
  endtask

  // one full pulse with a cadence enable every 'gap' cycles
  task automatic pulse_gap(input int gap, input string tag);
    cyc(1'b1, 1'b0, tag);
    for (int i = 0; i < W; i++) begin
      for (int j = 1; j < gap; j++) cyc(1'b0, 1'b0, tag);
      cyc(1'b0, 1'b1, tag);
    end
    cyc(1'b0, 1'b0, tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_n = 1'b0;
    m_act = 1'b0; m_tgl = 1'b0; m_cnt = 0;
    @(negedge clk);
    compare(tag);
    rst_n = 1'b1;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic finish_run;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog run did not complete");
    finish_run();
  end

  initial begin
    @(negedge clk);
    compare("R1 reset");
    do_reset("R1 reset");
    // R6: cadence with no tick leaves legs low
    for (int i = 0; i < 30; i++) cyc(1'b0, 1'b1, "R6 idle cadence");
    // R2 R3 R4: first pulse on leg A, cadence every cycle
    pulse_gap(1, "R3 first pulse leg A");
    pulse_gap(1, "R4 second pulse leg B");
    // R9: sweep cadence spacing
    for (int g = 1; g <= 4; g++) pulse_gap(g, "R9 cadence spacing");
    // R7: retrigger after every possible count
    for (int k = 0; k < W; k++) begin
      cyc(1'b1, 1'b0, "R7 retrigger first");
      for (int i = 0; i < k; i++) cyc(1'b0, 1'b1, "R7 retrigger count");
      cyc(1'b1, 1'b0, "R7 retrigger swap");
      for (int i = 0; i < W + 2; i++) cyc(1'b0, 1'b1, "R7 retrigger width");
    end
    // R8: tick and cadence on the same edge
    cyc(1'b1, 1'b1, "R8 coincident cadence");
    for (int i = 0; i < W + 2; i++) cyc(1'b0, 1'b1, "R8 width after coincident");
    cyc(1'b1, 1'b0, "R8 setup");
    cyc(1'b0, 1'b1, "R8 setup");
    cyc(1'b1, 1'b1, "R8 retrigger coincident");
    for (int i = 0; i < W + 2; i++) cyc(1'b0, 1'b1, "R8 width after retrigger");
    // R1 R3: reset in mid pulse, then next pulse is leg A again
    cyc(1'b1, 1'b0, "R1 pre-reset pulse");
    cyc(1'b1, 1'b0, "R1 pre-reset pulse");
    cyc(1'b0, 1'b1, "R1 pre-reset pulse");
    do_reset("R1 reset mid pulse");
    pulse_gap(2, "R3 leg A after reset");
    finish_run();
  end
endmodule